// File: doc/BRIEF.md
# Dual-Slot Transmit Frame Queue

This block is the transmit-side frame scheduler of an Ethernet MAC. Software hands it frames through a small write-only register interface. It first writes the buffer address, then the byte length, and the length write commits the frame. At most two frames are held at once, one being sent and one waiting, and the two slots are used alternately. The block fetches each frame from memory as 32-bit little-endian words through a request/response read port. It then streams the bytes to the MAC over a valid/ready byte interface. Preamble, FCS, collisions and the physical layer belong to other blocks.

Queue state is shown on plain status pins: a slot-free flag, an idle flag, a sticky completion flag that also drives the interrupt, and a sticky overflow flag. Software clears the two sticky flags by writing ones to the status register.

Two streams carry back-pressure. On the memory side a request is taken on a cycle where `mem_req_valid` and `mem_req_ready` are both high. Exactly one request is outstanding at a time, and its response arrives as a single `mem_rsp_valid` pulse that the block always accepts. On the MAC side a byte moves on a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the block keeps `tx_valid`, `tx_data` and `tx_last` unchanged.

Top module: `tpq_tx_queue`

## Requirements
- R1: A write to register offset 2 (length) commits a frame made of that length and the address last written to offset 1. Frames are transmitted strictly in commit order.
- R2: Two frame slots exist, and a frame holds its slot until its last byte is sent. `sts_slot_free` is high when fewer than two frames are held.
- R3: A length write made while both slots are held is ignored. It sets the sticky overflow flag (status bit 1, `sts_overflow`).
- R4: Each frame completion sets the sticky done flag (status bit 0, `sts_done`) and `irq`. Writing offset 3 clears each flag whose data bit is 1; bits written as 0 leave their flag unchanged.
- R5: `sts_idle` is high only when no frame is in progress and none is waiting.
- R6: A frame is fetched as 32-bit words from ascending word addresses, starting at the buffer address with its two low bits cleared. Only one request is outstanding at a time. Byte k of a word is bits 8k+7:8k, and bytes past the frame length in the final word are discarded.
- R7: The MAC stream holds `tx_valid`, `tx_data` and `tx_last` stable while `tx_ready` is low. `tx_last` marks the final byte of each frame.
- R8: Bit 0 of offset 0 is the transmit enable, and it is 0 after reset. While it is 0, no memory request is issued.
- R9: A frame of length zero completes without any memory request or MAC byte, and it still sets the done flag.
- R10: When another frame is waiting and transmit is enabled, its first memory request is presented in the cycle after the previous frame's last byte handshake.
- R11: After reset the queue is empty. In that state `sts_idle` and `sts_slot_free` are high, both sticky flags are low, and `tx_valid` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 control, 1 address, 2 length, 3 status clear |
| reg_wdata | input | DW | Register write data |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Word-aligned byte address of the read |
| mem_rsp_valid | input | 1 | Read data valid (one pulse per request) |
| mem_rsp_data | input | DW | Read data, little-endian bytes |
| tx_valid | output | 1 | MAC byte valid |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| sts_slot_free | output | 1 | A slot can take another frame |
| sts_idle | output | 1 | Nothing in progress or waiting |
| sts_done | output | 1 | Sticky frame-complete flag |
| sts_overflow | output | 1 | Sticky rejected-commit flag |
| irq | output | 1 | Interrupt, follows the done flag |

## Verification
The bench runs a single aligned frame with the MAC always ready. This shows the byte order within a word and the marking of the last byte. It then commits two frames and a rejected third while transmit is disabled, and sends them under alternating MAC back-pressure. That pattern tells apart commit order, full-queue rejection, the fetch hold while disabled and the one-cycle turnaround between frames. Last come a zero-length frame, which must complete without any fetch, and an unaligned 6-byte frame plus a 13-byte frame whose request counts show word alignment and the discard of trailing bytes.

// File: rtl/tpq_pkg.sv
package tpq_pkg;
  localparam int NSLOT = 2;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_ADDR = 2'd1;
  localparam logic [1:0] REG_LEN  = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_REQ,
    ENG_WAIT,
    ENG_SEND
  } eng_state_e;
endpackage

// File: rtl/tpq_regs.sv
module tpq_regs #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          full,
  input  logic          frame_done,
  output logic          tx_en,
  output logic          push,
  output logic [AW-1:0] push_addr,
  output logic [LW-1:0] push_len,
  output logic          done_flag,
  output logic          ovf_flag
);
  import tpq_pkg::*;

  logic len_wr, stat_wr;

  assign len_wr   = reg_wr_en && (reg_addr == REG_LEN);
  assign stat_wr  = reg_wr_en && (reg_addr == REG_STAT);
  assign push     = len_wr && !full;
  assign push_len = reg_wdata[LW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en     <= 1'b0;
      push_addr <= '0;
      done_flag <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      if (reg_wr_en && reg_addr == REG_CTRL) tx_en <= reg_wdata[0];
      if (reg_wr_en && reg_addr == REG_ADDR) push_addr <= reg_wdata[AW-1:0];
      done_flag <= frame_done | (done_flag & ~(stat_wr & reg_wdata[0]));
      ovf_flag  <= (len_wr & full) | (ovf_flag & ~(stat_wr & reg_wdata[1]));
    end
  end

  p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !(stat_wr && reg_wdata[0])) |=> done_flag);
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(stat_wr && reg_wdata[1])) |=> ovf_flag);
endmodule

// File: rtl/tpq_slots.sv
module tpq_slots #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [LW-1:0] push_len,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [LW-1:0] head_len,
  output logic          have_frame,
  output logic          full
);
  import tpq_pkg::*;
  localparam int CW = $clog2(NSLOT + 1);

  logic [AW-1:0] addr_q [NSLOT];
  logic [LW-1:0] len_q  [NSLOT];
  logic          wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  assign full       = (cnt == CW'(NSLOT));
  assign have_frame = (cnt != '0);
  assign head_addr  = addr_q[rd_ptr];
  assign head_len   = len_q[rd_ptr];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        len_q[g]  <= '0;
      end else if (push && !full && wr_ptr == 1'(g)) begin
        addr_q[g] <= push_addr;
        len_q[g]  <= push_len;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= 1'b0;
      rd_ptr <= 1'b0;
      cnt    <= '0;
    end else begin
      if (push && !full) wr_ptr <= ~wr_ptr;
      if (pop)           rd_ptr <= ~rd_ptr;
      case ({push && !full, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(NSLOT));
  p_pop_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> have_frame);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
endmodule

// File: rtl/tpq_engine.sv
module tpq_engine #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          have_frame,
  input  logic [AW-1:0] head_addr,
  input  logic [LW-1:0] head_len,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          pop
);
  import tpq_pkg::*;
  localparam int BPW = DW / 8;
  localparam int BW  = $clog2(BPW);

  eng_state_e    state_q;
  logic [AW-1:0] word_addr_q, head_word;
  logic [LW-1:0] rem_q;
  logic [BW-1:0] bidx_q;
  logic [DW-1:0] word_q;

  assign head_word = head_addr & ~AW'(BPW - 1);
  assign tx_valid  = (state_q == ENG_SEND);
  assign tx_data   = word_q[8*bidx_q +: 8];
  assign tx_last   = (rem_q == LW'(1));

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_addr  = word_addr_q;
    pop           = 1'b0;
    case (state_q)
      ENG_IDLE: if (tx_en && have_frame) begin
        if (head_len == '0) pop = 1'b1;
        else begin
          mem_req_valid = 1'b1;
          mem_req_addr  = head_word;
        end
      end
      ENG_REQ:  mem_req_valid = tx_en;
      ENG_SEND: pop = tx_ready && tx_last;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ENG_IDLE;
      word_addr_q <= '0;
      rem_q       <= '0;
      bidx_q      <= '0;
      word_q      <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: if (mem_req_valid && mem_req_ready) begin
          word_addr_q <= head_word;
          rem_q       <= head_len;
          state_q     <= ENG_WAIT;
        end
        ENG_REQ: if (mem_req_valid && mem_req_ready) state_q <= ENG_WAIT;
        ENG_WAIT: if (mem_rsp_valid) begin
          word_q  <= mem_rsp_data;
          bidx_q  <= '0;
          state_q <= ENG_SEND;
        end
        ENG_SEND: if (tx_ready) begin
          rem_q  <= rem_q - LW'(1);
          bidx_q <= bidx_q + BW'(1);
          if (tx_last) state_q <= ENG_IDLE;
          else if (bidx_q == BW'(BPW - 1)) begin
            word_addr_q <= word_addr_q + AW'(BPW);
            state_q     <= ENG_REQ;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  p_req_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> tx_en);
  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
  p_aligned_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[BW-1:0] == '0));
endmodule

// File: rtl/tpq_tx_queue.sv
module tpq_tx_queue #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          sts_slot_free,
  output logic          sts_idle,
  output logic          sts_done,
  output logic          sts_overflow,
  output logic          irq
);
  logic          tx_en, push, pop, full, have_frame;
  logic [AW-1:0] push_addr, head_addr;
  logic [LW-1:0] push_len, head_len;

  tpq_regs #(.AW(AW), .LW(LW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .full(full), .frame_done(pop), .tx_en(tx_en),
    .push(push), .push_addr(push_addr), .push_len(push_len),
    .done_flag(sts_done), .ovf_flag(sts_overflow)
  );

  tpq_slots #(.AW(AW), .LW(LW)) u_slots (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(push_addr),
    .push_len(push_len), .pop(pop), .head_addr(head_addr),
    .head_len(head_len), .have_frame(have_frame), .full(full)
  );

  tpq_engine #(.AW(AW), .LW(LW), .DW(DW)) u_engine (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .have_frame(have_frame),
    .head_addr(head_addr), .head_len(head_len),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .pop(pop)
  );

  assign sts_slot_free = !full;
  assign sts_idle      = !have_frame;
  assign irq           = sts_done;

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sts_idle |-> (!tx_valid && !mem_req_valid));
endmodule

// File: tb/tb_tpq_tx_queue.sv
module tb_tpq_tx_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_req_valid, mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        tx_valid, tx_ready = 1'b1, tx_last;
  logic [7:0]  tx_data;
  logic        sts_slot_free, sts_idle, sts_done, sts_overflow, irq;

  int checks = 0, failures = 0;
  int cyc = 0, req_cnt = 0, rx_cnt = 0, exp_cnt = 0;
  int last_cyc = 0, gap = -1;
  bit last_pend = 0, bp_mode = 0, finished = 0;
  logic [7:0] rx_buf [64];
  bit         rx_last [64];
  logic [7:0] exp_buf [64];
  bit         exp_last [64];

  tpq_tx_queue dut (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] word_at(input logic [31:0] a);
    for (int i = 0; i < 4; i++) word_at[8*i +: 8] = 8'(a + 32'(i)) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) mem_rsp_valid <= 1'b0;
    else begin
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      mem_rsp_data  <= word_at(mem_req_addr);
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_req_valid && mem_req_ready) begin
        req_cnt++;
        if (last_pend) begin gap = cyc - last_cyc; last_pend = 0; end
      end
      if (tx_valid && tx_ready && rx_cnt < 64) begin
        rx_buf[rx_cnt] = tx_data;
        rx_last[rx_cnt] = tx_last;
        rx_cnt++;
        if (tx_last) begin last_cyc = cyc; last_pend = 1; end
      end
    end
    cyc++;
  end

  always @(negedge clk) tx_ready <= bp_mode ? ~tx_ready : 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && !sts_idle; i++) @(negedge clk);
  endtask

  task automatic add_exp(input logic [31:0] a, input int len);
    for (int i = 0; i < len; i++) begin
      exp_buf[exp_cnt]  = 8'(((a & ~32'd3) + 32'(i))) ^ 8'h5A;
      exp_last[exp_cnt] = (i == len - 1);
      exp_cnt++;
    end
  endtask

  task automatic compare_stream(input string tag);
    int bad = -1;
    chk(rx_cnt == exp_cnt, tag, rx_cnt, exp_cnt);
    for (int i = 0; i < exp_cnt && i < rx_cnt; i++)
      if (bad < 0 && (rx_buf[i] !== exp_buf[i] || rx_last[i] != exp_last[i])) bad = i;
    if (bad >= 0) chk(0, tag, int'(rx_buf[bad]), int'(exp_buf[bad]));
    else chk(1, tag, 0, 0);
  endtask

  task automatic t_reset();
    chk(sts_idle && sts_slot_free, "R11 idle/free after reset", {sts_idle, sts_slot_free}, 3);
    chk(!sts_done && !sts_overflow && !irq, "R11 flags after reset", {sts_done, sts_overflow, irq}, 0);
    chk(!tx_valid && !mem_req_valid, "R11 valids after reset", {tx_valid, mem_req_valid}, 0);
  endtask

  task automatic t_single();
    wr(2'd0, 32'd1);
    wr(2'd1, 32'h100);
    add_exp(32'h100, 7);
    wr(2'd2, 32'd7);
    wait_idle();
    repeat (2) @(negedge clk);
    compare_stream("R1 R6 R7 single frame bytes and last flag");
    chk(sts_done && irq, "R4 done and irq after frame", {sts_done, irq}, 3);
    wr(2'd3, 32'd0);
    chk(sts_done, "R4 writing zero keeps done", sts_done, 1);
    wr(2'd3, 32'd1);
    chk(!sts_done && !irq, "R4 write-one clears done", {sts_done, irq}, 0);
  endtask

  task automatic t_pair_disabled();
    int r0;
    wr(2'd0, 32'd0);
    r0 = req_cnt;
    wr(2'd1, 32'h200);
    wr(2'd2, 32'd5);
    chk(sts_slot_free && !sts_idle, "R2 R5 one frame held", {sts_slot_free, sts_idle}, 2);
    wr(2'd1, 32'h240);
    wr(2'd2, 32'd9);
    chk(!sts_slot_free, "R2 both slots held", sts_slot_free, 0);
    wr(2'd1, 32'h280);
    wr(2'd2, 32'd4);
    chk(sts_overflow, "R3 overflow set on full commit", sts_overflow, 1);
    repeat (20) @(negedge clk);
    chk(req_cnt == r0, "R8 no fetch while disabled", req_cnt - r0, 0);
    add_exp(32'h200, 5);
    add_exp(32'h240, 9);
    last_pend = 0; gap = -1;
    bp_mode = 1;
    wr(2'd0, 32'd1);
    for (int i = 0; i < 2000 && rx_cnt < exp_cnt - 9; i++) @(negedge clk);
    @(negedge clk);
    chk(!sts_idle, "R5 not idle while second frame pending", sts_idle, 0);
    wait_idle();
    repeat (2) @(negedge clk);
    bp_mode = 0;
    compare_stream("R1 R3 R7 ordered pair under back-pressure");
    chk(gap == 1, "R10 next request one cycle after last byte", gap, 1);
    wr(2'd3, 32'd2);
    chk(!sts_overflow, "R3 overflow cleared by write-one", sts_overflow, 0);
  endtask

  task automatic t_zero_len();
    int r0, b0;
    wr(2'd3, 32'd3);
    r0 = req_cnt; b0 = rx_cnt;
    wr(2'd1, 32'h400);
    wr(2'd2, 32'd0);
    repeat (3) @(negedge clk);
    chk(sts_done && sts_idle, "R9 zero length completes", {sts_done, sts_idle}, 3);
    chk(req_cnt == r0 && rx_cnt == b0, "R9 zero length no fetch or byte", req_cnt - r0 + rx_cnt - b0, 0);
  endtask

  task automatic t_align();
    int r0;
    r0 = req_cnt;
    wr(2'd1, 32'h303);
    add_exp(32'h303, 6);
    wr(2'd2, 32'd6);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(req_cnt - r0 == 2, "R6 unaligned 6 bytes use 2 words", req_cnt - r0, 2);
    r0 = req_cnt;
    wr(2'd1, 32'h500);
    add_exp(32'h500, 13);
    wr(2'd2, 32'd13);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(req_cnt - r0 == 4, "R6 13 bytes use 4 words", req_cnt - r0, 4);
    compare_stream("R6 alignment and tail discard bytes");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_pair_disabled();
    t_zero_len();
    t_align();
    summary();
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
  end
endmodule